// File: doc/BRIEF.md
# Load and Store Lane Formatter

This block sits between the data-memory port and the register writeback stage. On the store side, it places register data into the correct byte lanes of a 32-bit memory word and produces a byte-write mask. On the load side, it extracts a byte, halfword or word from the returned memory word and widens it to the register width. Narrow results are filled with either zeros or copies of their top bit. A per-access flag reverses the byte order of halfword and word data in both directions.

Each access is captured in a request register. The memory-side outputs appear one cycle after the request. The memory returns read data during that same cycle. The formatted load result appears one cycle later still. Every stage accepts a new access on every cycle, so a stream of mixed loads and stores proceeds at one access per clock.

Top module: `mem_lane_fmt`

## Requirements
- R1: While reset is asserted and after it is released, `mem_valid`, `mem_we`, `acc_misalign`, `ld_valid` and `ld_misalign` are 0 until a request is accepted.
- R2: A byte load (size code 0) returns the lane chosen by `req_off`. Lane numbering is big-endian: offset 0 is bits 31:24 and offset 3 is bits 7:0.
- R3: With `req_signed` = 0, a byte or halfword load puts zeros in every result bit above the loaded data.
- R4: With `req_signed` = 1, a byte or halfword load copies the top bit of the loaded data into every higher result bit.
- R5: A halfword load (size code 1) at offset 0 returns bits 31:16, and at offset 2 returns bits 15:0. The lower-addressed byte is the more significant byte.
- R6: With `req_rev` = 1, halfword and word loads swap their bytes end for end before extension. For byte accesses, `req_rev` has no effect.
- R7: A byte store copies `req_wdata[7:0]` into all four lanes. It sets only the mask bit `mem_be[3-off]`, where bit 3 enables bits 31:24.
- R8: A halfword store copies the (optionally swapped) `req_wdata[15:0]` into both halves, with mask 1100 at offset 0 and 0011 at offset 2. A word store (size code 2) writes the (optionally byte-reversed) word with mask 1111.
- R9: A halfword at an odd offset, or a word at a non-zero offset, is misaligned. Such an access raises `acc_misalign`, drives `mem_we` = 0 and `mem_be` = 0, and a misaligned load returns `ld_misalign` = 1 with `ld_data` = 0.
- R10: Memory-side outputs for a request appear one cycle after it is accepted. `mem_rdata` is sampled at the end of that cycle, and the load result appears one cycle later. Back-to-back accesses complete one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-fill narrow load results |
| req_rev | input | 1 | Reverse byte order of the access |
| req_off | input | 2 | Byte offset within the memory word |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Memory access presented this cycle |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-write mask, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed store data |
| acc_misalign | output | 1 | Presented access is misaligned |
| mem_rdata | input | 32 | Read word returned during the `mem_valid` cycle |
| ld_valid | output | 1 | Formatted load result valid |
| ld_data | output | 32 | Extended load result |
| ld_misalign | output | 1 | Returned load was misaligned |

## Verification
Byte loads run over every offset, using a read word whose lanes mix set and clear top bits. This separates lane selection from the fill choice. Halfword and word loads and stores run with reversal on and off, using asymmetric byte values, so that a swap in the wrong place or at the wrong stage shows. Every misaligned offset is tried for both sizes. A long pseudo-random stream of mixed loads and stores with no idle cycles confirms ordering, the one-per-cycle rate, and that a load result appears only in the expected cycle.

// File: rtl/lane_fmt_pkg.sv
`timescale 1ns/1ps
package lane_fmt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_align_chk.sv
`timescale 1ns/1ps
module lane_align_chk
  import lane_fmt_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   off,
  output logic               misal
);
  always_comb begin
    case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = off[0];
      default: misal = |off;
    endcase
  end
endmodule

// File: rtl/lane_store_pack.sv
`timescale 1ns/1ps
module lane_store_pack
  import lane_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBYTES = DATA_W / 8,
  parameter int unsigned OFF_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] wdata,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              rev,
  input  logic              is_store,
  input  logic              misal,
  output logic [DATA_W-1:0] data,
  output logic [NBYTES-1:0] be
);
  logic [15:0] half_v;

  always_comb begin
    half_v = rev ? {wdata[7:0], wdata[15:8]} : wdata[15:0];
  end

  always_comb begin
    data = '0;
    be   = '0;
    case (size)
      SZ_BYTE: begin
        data = {NBYTES{wdata[7:0]}};
        for (int i = 0; i < NBYTES; i++)
          be[i] = ((NBYTES - 1 - i) == int'(off));
      end
      SZ_HALF: begin
        data = {(NBYTES/2){half_v}};
        for (int i = 0; i < NBYTES; i++)
          be[i] = ((NBYTES - 1 - i) == int'(off)) || ((NBYTES - 2 - i) == int'(off));
      end
      default: begin
        for (int j = 0; j < NBYTES; j++)
          data[DATA_W-1-8*j -: 8] = rev ? wdata[8*j +: 8] : wdata[DATA_W-1-8*j -: 8];
        be = '1;
      end
    endcase
    if (!is_store || misal) be = '0;
  end
endmodule

// File: rtl/lane_load_unpack.sv
`timescale 1ns/1ps
module lane_load_unpack
  import lane_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBYTES = DATA_W / 8,
  parameter int unsigned OFF_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sgn,
  input  logic              rev,
  input  logic              misal,
  output logic [DATA_W-1:0] data
);
  logic [7:0]       lane [NBYTES];
  logic [OFF_W-1:0] off_nx;
  logic [7:0]       b_sel, h_hi, h_lo;

  always_comb begin
    for (int i = 0; i < NBYTES; i++)
      lane[i] = rdata[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    off_nx = off + 1'b1;
    b_sel  = lane[off];
    h_hi   = rev ? lane[off_nx] : lane[off];
    h_lo   = rev ? lane[off]    : lane[off_nx];
  end

  always_comb begin
    data = '0;
    case (size)
      SZ_BYTE: data = {{(DATA_W-8){sgn & b_sel[7]}}, b_sel};
      SZ_HALF: data = {{(DATA_W-16){sgn & h_hi[7]}}, h_hi, h_lo};
      default: begin
        for (int j = 0; j < NBYTES; j++)
          data[DATA_W-1-8*j -: 8] = rev ? lane[NBYTES-1-j] : lane[j];
      end
    endcase
    if (misal) data = '0;
  end
endmodule

// File: rtl/mem_lane_fmt.sv
`timescale 1ns/1ps
module mem_lane_fmt
  import lane_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NBYTES = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_rev,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [NBYTES-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc_misalign,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_misalign
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ln = rst_sync_q[1];

  // ---------------- stage 1: request capture ----------------
  acc_size_e         req_size_e;
  logic              req_misal;
  logic [DATA_W-1:0] pack_data;
  logic [NBYTES-1:0] pack_be;

  assign req_size_e = acc_size_e'(req_size);

  lane_align_chk #(.OFF_W(OFF_W)) u_align (
    .size  (req_size_e),
    .off   (req_off),
    .misal (req_misal)
  );

  lane_store_pack #(.DATA_W(DATA_W), .NBYTES(NBYTES), .OFF_W(OFF_W)) u_pack (
    .wdata    (req_wdata),
    .size     (req_size_e),
    .off      (req_off),
    .rev      (req_rev),
    .is_store (req_store),
    .misal    (req_misal),
    .data     (pack_data),
    .be       (pack_be)
  );

  logic              s1_valid_d, s1_ce;
  logic              s1_valid_q, s1_store_q, s1_sgn_q, s1_rev_q, s1_mis_q;
  acc_size_e         s1_size_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic [NBYTES-1:0] s1_be_q;
  logic [DATA_W-1:0] s1_wdata_q;

  always_comb begin
    s1_valid_d = req_valid;
    s1_ce      = req_valid;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) s1_valid_q <= 1'b0;
    else         s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      s1_store_q <= 1'b0;
      s1_sgn_q   <= 1'b0;
      s1_rev_q   <= 1'b0;
      s1_mis_q   <= 1'b0;
      s1_size_q  <= SZ_BYTE;
      s1_off_q   <= '0;
      s1_be_q    <= '0;
      s1_wdata_q <= '0;
    end else if (s1_ce) begin
      s1_store_q <= req_store;
      s1_sgn_q   <= req_signed;
      s1_rev_q   <= req_rev;
      s1_mis_q   <= req_misal;
      s1_size_q  <= req_size_e;
      s1_off_q   <= req_off;
      s1_be_q    <= pack_be;
      s1_wdata_q <= pack_data;
    end
  end

  assign mem_valid    = s1_valid_q;
  assign mem_we       = s1_valid_q & s1_store_q & ~s1_mis_q;
  assign mem_be       = s1_valid_q ? s1_be_q : '0;
  assign mem_wdata    = s1_wdata_q;
  assign acc_misalign = s1_valid_q & s1_mis_q;

  // ---------------- stage 2: data return and format ----------------
  logic              s2_valid_d, s2_ce;
  logic              s2_valid_q, s2_sgn_q, s2_rev_q, s2_mis_q;
  acc_size_e         s2_size_q;
  logic [OFF_W-1:0]  s2_off_q;
  logic [DATA_W-1:0] s2_rdata_q;

  always_comb begin
    s2_valid_d = s1_valid_q & ~s1_store_q;
    s2_ce      = s2_valid_d;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) s2_valid_q <= 1'b0;
    else         s2_valid_q <= s2_valid_d;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      s2_sgn_q   <= 1'b0;
      s2_rev_q   <= 1'b0;
      s2_mis_q   <= 1'b0;
      s2_size_q  <= SZ_BYTE;
      s2_off_q   <= '0;
      s2_rdata_q <= '0;
    end else if (s2_ce) begin
      s2_sgn_q   <= s1_sgn_q;
      s2_rev_q   <= s1_rev_q;
      s2_mis_q   <= s1_mis_q;
      s2_size_q  <= s1_size_q;
      s2_off_q   <= s1_off_q;
      s2_rdata_q <= mem_rdata;
    end
  end

  lane_load_unpack #(.DATA_W(DATA_W), .NBYTES(NBYTES), .OFF_W(OFF_W)) u_unpack (
    .rdata (s2_rdata_q),
    .size  (s2_size_q),
    .off   (s2_off_q),
    .sgn   (s2_sgn_q),
    .rev   (s2_rev_q),
    .misal (s2_mis_q),
    .data  (ld_data)
  );

  assign ld_valid    = s2_valid_q;
  assign ld_misalign = s2_valid_q & s2_mis_q;

  // ---------------- assertions ----------------
  // R9
  misal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    acc_misalign |-> (mem_be == '0) && !mem_we);

  // R7
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    mem_we |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2) || ($countones(mem_be) == NBYTES));

  // R10
  mem_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    mem_valid |-> $past(req_valid));

  // R10
  ld_follows_mem_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    ld_valid |-> $past(mem_valid && !mem_we && (mem_be == '0)));

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (ld_valid && (s2_size_q == SZ_BYTE) && !s2_sgn_q) |-> (ld_data[DATA_W-1:8] == '0));

  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (ld_valid && (s2_size_q == SZ_HALF) && s2_sgn_q && !s2_mis_q) |->
      ((ld_data[DATA_W-1:15] == '0) || (ld_data[DATA_W-1:15] == '1)));
endmodule

// File: tb/sim_mem_lane_fmt.sv
`timescale 1ns/1ps
module sim_mem_lane_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_rev = 1'b0;
  logic [1:0]  req_size = 2'd0, req_off = 2'd0;
  logic [31:0] req_wdata = '0, mem_rdata = '0;
  logic        mem_valid, mem_we, acc_misalign, ld_valid, ld_misalign;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;

  always #10 clk = ~clk;  // 50 MHz

  mem_lane_fmt u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_rev(req_rev), .req_off(req_off),
    .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .acc_misalign(acc_misalign), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_misalign(ld_misalign)
  );

  typedef struct packed {
    logic        is_load;
    logic        we;
    logic [3:0]  be;
    logic [31:0] data;
    logic        mis;
  } mem_exp_t;

  typedef struct packed {
    logic [31:0] data;
    logic        mis;
  } ld_exp_t;

  mem_exp_t memq[$];
  string    memtag[$];
  ld_exp_t  ldq[$];
  string    ldtag[$];

  int checks = 0, errors = 0;
  logic mon_on = 1'b0, exp_ldv = 1'b0, done = 1'b0;
  logic [31:0] pend_rdata = '0;

  function automatic logic is_misal(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return off[0];
    return off != 2'd0;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic [1:0] sz,
                                           input logic [1:0] off, input logic sg, input logic rv);
    logic [7:0] b [4];
    logic [7:0] v;
    logic [15:0] h;
    for (int i = 0; i < 4; i++) b[i] = rd[31-8*i -: 8];
    if (is_misal(sz, off)) return 32'h0;
    if (sz == 2'd0) begin
      v = b[off];
      return sg ? {{24{v[7]}}, v} : {24'h0, v};
    end
    if (sz == 2'd1) begin
      h = {b[off], b[off+2'd1]};
      if (rv) h = {h[7:0], h[15:8]};
      return sg ? {{16{h[15]}}, h} : {16'h0, h};
    end
    return rv ? bswap(rd) : rd;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one access per call, expectations pushed as it is issued
  task automatic issue(input string tag, input logic st, input logic [1:0] sz, input logic sg,
                       input logic rv, input logic [1:0] off, input logic [31:0] wd, input logic [31:0] rd);
    mem_exp_t me;
    ld_exp_t  le;
    logic [15:0] h;
    @(negedge clk);
    mem_rdata  = pend_rdata;
    pend_rdata = rd;
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_rev = rv; req_off = off; req_wdata = wd;
    me.is_load = !st;
    me.mis     = is_misal(sz, off);
    me.we      = st && !me.mis;
    me.be      = 4'h0;
    me.data    = 32'h0;
    if (st) begin
      if (sz == 2'd0) begin
        me.data = {4{wd[7:0]}};
        me.be   = 4'b1000 >> off;
      end else if (sz == 2'd1) begin
        h = rv ? {wd[7:0], wd[15:8]} : wd[15:0];
        me.data = {h, h};
        me.be   = (off == 2'd0) ? 4'b1100 : 4'b0011;
      end else begin
        me.data = rv ? bswap(wd) : wd;
        me.be   = 4'b1111;
      end
      if (me.mis) me.be = 4'h0;
    end
    memq.push_back(me);
    memtag.push_back(tag);
    if (!st) begin
      le.data = exp_load(rd, sz, off, sg, rv);
      le.mis  = me.mis;
      ldq.push_back(le);
      ldtag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid  = 1'b0;
      mem_rdata  = pend_rdata;
      pend_rdata = '0;
    end
  endtask

  // monitor: pops and compares as results come out
  always @(negedge clk) begin
    if (mon_on) begin
      mem_exp_t me;
      ld_exp_t  le;
      string    t;
      chk("R10", "ld_valid timing", {31'h0, ld_valid}, {31'h0, exp_ldv});
      if (ld_valid) begin
        if (ldq.size() == 0) chk("R10", "unexpected load result", 32'h1, 32'h0);
        else begin
          le = ldq.pop_front();
          t  = ldtag.pop_front();
          chk(t, "ld_data", ld_data, le.data);
          chk(t, "ld_misalign", {31'h0, ld_misalign}, {31'h0, le.mis});
        end
      end
      exp_ldv = 1'b0;
      if (mem_valid) begin
        if (memq.size() == 0) chk("R10", "unexpected mem access", 32'h1, 32'h0);
        else begin
          me = memq.pop_front();
          t  = memtag.pop_front();
          chk(t, "mem_we", {31'h0, mem_we}, {31'h0, me.we});
          chk(t, "mem_be", {28'h0, mem_be}, {28'h0, me.be});
          chk(t, "acc_misalign", {31'h0, acc_misalign}, {31'h0, me.mis});
          if (me.we) chk(t, "mem_wdata", mem_wdata, me.data);
          exp_ldv = me.is_load;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "mem_valid in reset", {31'h0, mem_valid}, 32'h0);
    chk("R1", "ld_valid in reset", {31'h0, ld_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "mem_valid after reset", {31'h0, mem_valid}, 32'h0);
    chk("R1", "mem_we after reset", {31'h0, mem_we}, 32'h0);
    chk("R1", "acc_misalign after reset", {31'h0, acc_misalign}, 32'h0);
    chk("R1", "ld_valid after reset", {31'h0, ld_valid}, 32'h0);
    chk("R1", "ld_misalign after reset", {31'h0, ld_misalign}, 32'h0);
    mon_on = 1'b1;

    // R2 R3 R4: byte lanes, zero and sign fill
    for (int o = 0; o < 4; o++) begin
      issue("R2", 1'b0, 2'd0, 1'b0, 1'b0, o[1:0], 32'h0, 32'h817FC324);
      issue("R3", 1'b0, 2'd0, 1'b0, 1'b0, o[1:0], 32'h0, 32'hF08E1BA9);
      issue("R4", 1'b0, 2'd0, 1'b1, 1'b0, o[1:0], 32'h0, 32'h817FC324);
      issue("R6", 1'b0, 2'd0, 1'b1, 1'b1, o[1:0], 32'h0, 32'h817FC324);
    end
    // R5 R6: halfword lanes, reversal before fill
    for (int o = 0; o < 4; o += 2) begin
      issue("R5", 1'b0, 2'd1, 1'b0, 1'b0, o[1:0], 32'h0, 32'hA53C7E91);
      issue("R4", 1'b0, 2'd1, 1'b1, 1'b0, o[1:0], 32'h0, 32'hA53C7E91);
      issue("R3", 1'b0, 2'd1, 1'b0, 1'b0, o[1:0], 32'h0, 32'hC3D2E1F0);
      issue("R6", 1'b0, 2'd1, 1'b1, 1'b1, o[1:0], 32'h0, 32'h3CA5917E);
      issue("R6", 1'b0, 2'd1, 1'b0, 1'b1, o[1:0], 32'h0, 32'h3CA5917E);
    end
    issue("R6", 1'b0, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0, 32'h01234567);
    issue("R6", 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 32'h0, 32'h01234567);
    idle(3);

    // R7 R8: stores
    for (int o = 0; o < 4; o++) begin
      issue("R7", 1'b1, 2'd0, 1'b0, 1'b0, o[1:0], 32'h123456AB, 32'h0);
      issue("R7", 1'b1, 2'd0, 1'b0, 1'b1, o[1:0], 32'hCAFE0017, 32'h0);
    end
    issue("R8", 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 32'h9999A1B2, 32'h0);
    issue("R8", 1'b1, 2'd1, 1'b0, 1'b1, 2'd2, 32'h9999A1B2, 32'h0);
    issue("R8", 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'h89ABCDEF, 32'h0);
    issue("R8", 1'b1, 2'd2, 1'b0, 1'b1, 2'd0, 32'h89ABCDEF, 32'h0);

    // R9: every misaligned case, loads and stores
    for (int o = 1; o < 4; o++) begin
      issue("R9", 1'b1, 2'd2, 1'b0, 1'b0, o[1:0], 32'hFFFFFFFF, 32'h0);
      issue("R9", 1'b0, 2'd2, 1'b1, 1'b0, o[1:0], 32'h0, 32'hFFFFFFFF);
    end
    for (int o = 1; o < 4; o += 2) begin
      issue("R9", 1'b1, 2'd1, 1'b0, 1'b1, o[1:0], 32'hFFFFFFFF, 32'h0);
      issue("R9", 1'b0, 2'd1, 1'b1, 1'b0, o[1:0], 32'h0, 32'h80808080);
    end

    // R10: back-to-back mixed stream
    lcg = 32'h1D872B41;
    for (int n = 0; n < 60; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      issue("R10", lcg[31], (lcg[30:29] == 2'd3) ? 2'd2 : lcg[30:29], lcg[28], lcg[27],
            lcg[26:25], lcg ^ 32'h5A5A0F0F, {lcg[15:0], lcg[31:16]});
    end
    idle(4);
    chk("R10", "pending mem items", memq.size(), 32'h0);
    chk("R10", "pending load items", ldq.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule